// File: doc/BRIEF.md
# Threshold Peak Picker with Neighbour Suppression

This block takes a finished energy profile over a window of delay bins (two bins per chip) and extracts up to a fixed number of path candidates from it. Each candidate is reported as a delay index together with its energy. Only bins strictly above a programmable threshold are considered. The search is iterative. Each round takes the strongest bin still eligible and records it. The bins one position to either side, which lie half a chip away, are then struck out so that a single path cannot be reported twice.

The profile is read through a plain synchronous memory-read port with one cycle of latency. Every round is one sequential sweep over all bins. The first sweep also builds the candidate mask from the threshold comparison. A start pulse launches a search and a one-cycle done pulse closes it. The result list and its count then stay unchanged until the next accepted start. Selection runs in decreasing energy order, so stopping after the maximum number of rounds gives the same list as collecting every peak and keeping the strongest ones.

Top module: `peak_picker`

## Requirements
- R1: After reset, `done`, `busy` and `rd_en` are 0 and `peak_count` is 0.
- R2: The threshold is captured at the accepted start. A bin is a candidate only if its energy is strictly greater than that threshold, so a bin equal to the threshold is never reported.
- R3: Each round reports the largest energy still in the candidate set. Slot 0 holds the first selection, so slot energies never increase with the slot index.
- R4: After a selection, the selected bin and its two adjacent bins (index −1 and +1) leave the candidate set. Bin 0 and bin NBINS−1 have only their single inner neighbour removed, and nothing wraps around.
- R5: When energies are equal, the bin with the lower delay index is selected first.
- R6: `peak_count` equals min(MAX_PEAKS, number of peaks found) and never exceeds MAX_PEAKS. Slot k holds its delay at `peak_delay[k*AW +: AW]` and its energy at `peak_energy[k*EW +: EW]`.
- R7: A profile with no bin above the threshold ends with `peak_count` = 0 and a done pulse.
- R8: `done` lasts one cycle. The outputs hold until the next start. A start that arrives while `busy` is 1 is ignored.
- R9: Each round reads addresses 0 to NBINS−1 in increasing order, one per cycle with `rd_en` high. `rd_data` is taken one cycle after its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (ignored while busy) |
| thresh | input | EW | Energy threshold, sampled at start |
| rd_en | output | 1 | Profile read strobe |
| rd_addr | output | AW | Profile read address |
| rd_data | input | EW | Profile energy, one cycle after rd_addr |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| peak_count | output | CW | Number of valid result slots |
| peak_delay | output | MAX_PEAKS*AW | Delay index per slot |
| peak_energy | output | MAX_PEAKS*EW | Energy per slot |

## Verification
A candidate mask that is not cleared correctly shows up as a duplicate or as an adjacent bin in the result list. A mask that is cleared too widely shows up as a missing peak. In both cases the error is visible at the done pulse of the same search. A fault in the running-maximum tracker reorders the slots or breaks equal-energy ties the wrong way, and this also appears at that done pulse. Faults in the address sequencing or the threshold latch change which bins are eligible, so the count or the slot contents are wrong the first time a profile touches the affected bins.

// File: rtl/pp_pkg.sv
// Shared types for the peak picker.
package pp_pkg;
    typedef enum logic [2:0] {
        PP_IDLE   = 3'd0,
        PP_SCAN   = 3'd1,
        PP_DRAIN  = 3'd2,
        PP_DECIDE = 3'd3,
        PP_FIN    = 3'd4
    } pp_state_t;
endpackage

// File: rtl/pp_seq.sv
// Search sequencer: drives one full address sweep per round, delays the
// address to line up with returned data, and decides after each round
// whether to record a peak and continue. Assumes a 1-cycle read latency.
module pp_seq
    import pp_pkg::*;
#(
    parameter int NBINS = 512,
    parameter int AW    = $clog2(NBINS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          have_peak,
    input  logic          last_slot,
    output logic          accept,
    output logic          pass_clr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          dval,
    output logic [AW-1:0] daddr,
    output logic          first_pass,
    output logic          push,
    output logic          busy,
    output logic          done
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(NBINS - 1);

    pp_state_t     state;
    logic [AW-1:0] addr;

    assign accept   = (state == PP_IDLE) && start;
    assign push     = (state == PP_DECIDE) && have_peak;
    assign pass_clr = accept || (push && !last_slot);
    assign rd_en    = (state == PP_SCAN);
    assign rd_addr  = addr;
    assign busy     = (state != PP_IDLE);
    assign done     = (state == PP_FIN);

    // State, sweep address and pass flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PP_IDLE;
            addr       <= '0;
            first_pass <= 1'b0;
        end else begin
            case (state)
                PP_IDLE: if (start) begin
                    state      <= PP_SCAN;
                    addr       <= '0;
                    first_pass <= 1'b1;
                end
                PP_SCAN: begin
                    if (addr == LAST_ADDR) state <= PP_DRAIN;
                    else                   addr  <= addr + 1'b1;
                end
                PP_DRAIN: state <= PP_DECIDE;
                PP_DECIDE: begin
                    if (have_peak && !last_slot) begin
                        state      <= PP_SCAN;
                        addr       <= '0;
                        first_pass <= 1'b0;
                    end else begin
                        state <= PP_FIN;
                    end
                end
                default: state <= PP_IDLE;
            endcase
        end
    end

    // Align address with the returned read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dval  <= 1'b0;
            daddr <= '0;
        end else begin
            dval  <= rd_en;
            daddr <= addr;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != LAST_ADDR) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));
endmodule

// File: rtl/pp_mask.sv
// Candidate mask: one bit per bin. Written from the threshold compare on
// the first sweep, then cleared around each selected bin (no wrap).
module pp_mask #(
    parameter int NBINS = 512,
    parameter int AW    = $clog2(NBINS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic          wr_bit,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    input  logic [AW-1:0] rd_idx,
    output logic          rd_bit
);
    localparam logic [AW-1:0] TOP_IDX = AW'(NBINS - 1);

    logic [NBINS-1:0] mask;
    logic [NBINS-1:0] kill;

    // Bins to strike out around the chosen one.
    always_comb begin
        kill = '0;
        kill[clr_idx] = 1'b1;
        if (clr_idx != '0)      kill[clr_idx - 1'b1] = 1'b1;
        if (clr_idx != TOP_IDX) kill[clr_idx + 1'b1] = 1'b1;
    end

    // Mask write on first sweep, clear on selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_en) begin
            mask[wr_idx] <= wr_bit;
        end else if (clr_en) begin
            mask <= mask & ~kill;
        end
    end

    assign rd_bit = mask[rd_idx];

    // R4
    sel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> !mask[$past(clr_idx)]);
endmodule

// File: rtl/pp_max_track.sv
// Running maximum over one sweep. Strict greater-than keeps the earliest
// (lowest-index) bin on equal energy, as bins arrive in increasing order.
module pp_max_track #(
    parameter int AW = 9,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [AW-1:0] idx,
    input  logic [EW-1:0] energy,
    output logic          have,
    output logic [AW-1:0] best_idx,
    output logic [EW-1:0] best_e
);
    // Hold the best bin seen since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have     <= 1'b0;
            best_idx <= '0;
            best_e   <= '0;
        end else if (upd && (!have || energy > best_e)) begin
            have     <= 1'b1;
            best_idx <= idx;
            best_e   <= energy;
        end
    end

    // R3
    best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have && !clr) |=> (best_e >= $past(best_e)));
endmodule

// File: rtl/pp_result_list.sv
// Result slots filled in selection order; held until the next start.
module pp_result_list #(
    parameter int MAX_PEAKS = 4,
    parameter int AW        = 9,
    parameter int EW        = 16,
    parameter int CW        = $clog2(MAX_PEAKS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    push,
    input  logic [AW-1:0]           p_idx,
    input  logic [EW-1:0]           p_e,
    output logic                    last_slot,
    output logic [CW-1:0]           count,
    output logic [MAX_PEAKS*AW-1:0] delays,
    output logic [MAX_PEAKS*EW-1:0] energies
);
    localparam logic [CW-1:0] CMAX = CW'(MAX_PEAKS);

    logic [EW-1:0] prev_e;

    assign last_slot = (count == CMAX - 1'b1);

    // Slot storage, one register set per slot.
    for (genvar k = 0; k < MAX_PEAKS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                delays[k*AW +: AW]   <= '0;
                energies[k*EW +: EW] <= '0;
            end else if (push && count == CW'(k)) begin
                delays[k*AW +: AW]   <= p_idx;
                energies[k*EW +: EW] <= p_e;
            end
        end
    end

    // Count and last-recorded energy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count  <= '0;
            prev_e <= '0;
        end else if (push) begin
            count  <= count + 1'b1;
            prev_e <= p_e;
        end
    end

    // R6
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CMAX);
    // R3
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count != '0) |-> (p_e <= prev_e));
endmodule

// File: rtl/peak_picker.sv
// Top: threshold peak picker with half-chip neighbour suppression.
// Assumes 2 bins per chip and a profile memory with 1-cycle read latency.
module peak_picker #(
    parameter int NBINS     = 512,
    parameter int EW        = 16,
    parameter int MAX_PEAKS = 4,
    parameter int AW        = $clog2(NBINS),
    parameter int CW        = $clog2(MAX_PEAKS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [EW-1:0]           thresh,
    output logic                    rd_en,
    output logic [AW-1:0]           rd_addr,
    input  logic [EW-1:0]           rd_data,
    output logic                    busy,
    output logic                    done,
    output logic [CW-1:0]           peak_count,
    output logic [MAX_PEAKS*AW-1:0] peak_delay,
    output logic [MAX_PEAKS*EW-1:0] peak_energy
);
    logic          accept, pass_clr, dval, first_pass, push, last_slot;
    logic [AW-1:0] daddr, best_idx;
    logic [EW-1:0] best_e, thresh_q;
    logic          have, above, mask_bit, eligible;

    // Threshold latched at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      thresh_q <= '0;
        else if (accept) thresh_q <= thresh;
    end

    assign above    = (rd_data > thresh_q);
    assign eligible = first_pass ? above : mask_bit;

    pp_seq #(.NBINS(NBINS), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .have_peak(have), .last_slot(last_slot),
        .accept(accept), .pass_clr(pass_clr),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .dval(dval), .daddr(daddr), .first_pass(first_pass),
        .push(push), .busy(busy), .done(done)
    );

    pp_mask #(.NBINS(NBINS), .AW(AW)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dval && first_pass), .wr_idx(daddr), .wr_bit(above),
        .clr_en(push), .clr_idx(best_idx),
        .rd_idx(daddr), .rd_bit(mask_bit)
    );

    pp_max_track #(.AW(AW), .EW(EW)) u_max (
        .clk(clk), .rst_n(rst_n), .clr(pass_clr),
        .upd(dval && eligible), .idx(daddr), .energy(rd_data),
        .have(have), .best_idx(best_idx), .best_e(best_e)
    );

    pp_result_list #(.MAX_PEAKS(MAX_PEAKS), .AW(AW), .EW(EW), .CW(CW)) u_list (
        .clk(clk), .rst_n(rst_n), .clr(accept), .push(push),
        .p_idx(best_idx), .p_e(best_e), .last_slot(last_slot),
        .count(peak_count), .delays(peak_delay), .energies(peak_energy)
    );

    // R2
    above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (best_e > thresh_q));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(peak_count));
endmodule

// File: tb/sim_peak_picker.sv
module sim_peak_picker;
    localparam int CLK_PERIOD = 10;
    localparam int NBINS = 512;
    localparam int EW = 16;
    localparam int LP = 4;
    localparam int AW = 9;
    localparam int CW = 3;

    logic clk = 0, rst_n = 0, start = 0;
    logic [EW-1:0] thresh = '0;
    logic rd_en, busy, done;
    logic [AW-1:0] rd_addr;
    logic [EW-1:0] rd_data;
    logic [CW-1:0] peak_count;
    logic [LP*AW-1:0] peak_delay;
    logic [LP*EW-1:0] peak_energy;

    int tests = 0, fails = 0;
    logic [EW-1:0] prof [NBINS];

    int exp_cnt_q[$];
    int exp_d_q[$];
    int exp_e_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    peak_picker u0 (.clk(clk), .rst_n(rst_n), .start(start), .thresh(thresh),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .done(done), .peak_count(peak_count), .peak_delay(peak_delay),
        .peak_energy(peak_energy));

    // Profile memory model, 1-cycle latency (R9).
    always_ff @(posedge clk) if (rd_en) rd_data <= prof[rd_addr];

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_prof();
        for (int i = 0; i < NBINS; i++) prof[i] = '0;
    endtask

    // Reference: iterative max, strict threshold, +-1 suppression.
    task automatic push_expected(int thr, string tag);
        bit cand [NBINS];
        int n = 0;
        for (int i = 0; i < NBINS; i++) cand[i] = (int'(prof[i]) > thr);
        for (int r = 0; r < LP; r++) begin
            int bi = -1;
            for (int i = 0; i < NBINS; i++)
                if (cand[i] && (bi < 0 || prof[i] > prof[bi])) bi = i;
            if (bi < 0) break;
            exp_d_q.push_back(bi);
            exp_e_q.push_back(int'(prof[bi]));
            n++;
            cand[bi] = 0;
            if (bi > 0) cand[bi-1] = 0;
            if (bi < NBINS-1) cand[bi+1] = 0;
        end
        for (int r = n; r < LP; r++) begin
            exp_d_q.push_back(0);
            exp_e_q.push_back(0);
        end
        exp_cnt_q.push_back(n);
        tag_q.push_back(tag);
    endtask

    // Driver: queue expectation, pulse start, wait for end.
    task automatic run_search(int thr, string tag);
        push_expected(thr, tag);
        @(negedge clk);
        thresh = EW'(thr);
        start = 1;
        @(negedge clk);
        start = 0;
        wait (done);
        @(negedge clk);
    endtask

    // Monitor: compare on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_cnt_q.size() == 0) begin
                check("R8 unexpected done", 1, 0);
            end else begin
                string t = tag_q.pop_front();
                check({t, " R6 count"}, int'(peak_count), exp_cnt_q.pop_front());
                for (int k = 0; k < LP; k++) begin
                    check({t, " R3 delay"}, int'(peak_delay[k*AW +: AW]), exp_d_q.pop_front());
                    check({t, " R3 energy"}, int'(peak_energy[k*EW +: EW]), exp_e_q.pop_front());
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int held;
        clear_prof();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 rd_en", int'(rd_en), 0);
        check("R1 count", int'(peak_count), 0);

        // R3 basic ordering
        clear_prof();
        prof[100] = 500; prof[200] = 300; prof[300] = 400;
        run_search(50, "R3 basic");

        // R4 adjacent suppression: 11 dropped, 12 kept
        clear_prof();
        prof[10] = 100; prof[11] = 90; prof[12] = 80;
        run_search(20, "R4 neighbour");

        // R4 edges, no wrap
        clear_prof();
        prof[0] = 200; prof[1] = 150; prof[510] = 170; prof[511] = 180;
        run_search(20, "R4 edge");

        // R5 ties
        clear_prof();
        prof[80] = 77; prof[40] = 77; prof[300] = 77;
        run_search(10, "R5 tie");

        // R2 equal to threshold is not a candidate
        clear_prof();
        prof[5] = 50; prof[20] = 51;
        run_search(50, "R2 threshold");

        // R6 more than MAX_PEAKS peaks
        clear_prof();
        prof[30] = 60; prof[90] = 900; prof[150] = 300;
        prof[220] = 700; prof[330] = 100; prof[450] = 800;
        run_search(40, "R6 limit");

        // R7 empty
        clear_prof();
        prof[7] = 30;
        run_search(30, "R7 empty");

        // R8 start while busy ignored, then hold
        clear_prof();
        prof[64] = 400; prof[128] = 200;
        push_expected(100, "R8 busy-start");
        @(negedge clk);
        thresh = 100; start = 1;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        thresh = 300; start = 1;  // would drop bin 128 if taken
        @(negedge clk);
        start = 0;
        wait (done);
        @(negedge clk);
        held = int'(peak_count);
        repeat (50) @(negedge clk);
        check("R8 hold count", int'(peak_count), held);
        check("R8 hold delay", int'(peak_delay[AW +: AW]), 128);
        check("R8 done low", int'(done), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule